// File: doc/BRIEF.md
# Transaction-Indexed Buffer Pointer

This block is the host-side address path into one channel's data buffer. The buffer holds a sequence of transactions laid out back to back, and the length of each one comes from a configuration table. The host does not handle raw buffer addresses. It names a transaction number and a byte offset inside that transaction. The block adds the offset to the start of that transaction, which is the running sum of the lengths of all earlier transactions. Bytes reserved for read transactions, filled with dummy FFh bytes by the host, count toward these lengths. Slave addresses are kept elsewhere and take no buffer space.

Each data access strobe presents the current pointer to the buffer RAM and then moves the pointer forward by one byte. A pointer-reset strobe sends the pointer back to the selected transaction and offset. An access that falls outside the configured data, or beyond the physical buffer, reaches no buffer location. It raises a sticky error flag and leaves the pointer where it is, so the pointer never wraps.

Top module: `bufptr_top`

## Requirements
- R1: After reset the pointer is 0 and the error flag is low. Every length is 0 and the transaction count is 0, so the first access is refused until lengths and a count are written. Once they are written, an access reaches address 0.
- R2: Writing the transaction select or the offset loads the pointer with base(select) + offset. base(k) is the sum of lengths 0..k-1. The new address is presented from the next cycle on.
- R3: An access whose pointer is inside the valid region raises `buf_en` in the same cycle, with `buf_addr` equal to the pointer. The pointer is one higher in the next cycle.
- R4: A `ptr_rst` strobe returns the pointer to base(select) + offset. It uses the select and offset values currently held.
- R5: The valid region is [0, total), where total is the sum of the first `count` lengths. An access with the pointer at or past total keeps `buf_en` low, sets the error flag after the clock edge, and leaves the pointer unchanged.
- R6: The valid region is also capped at DEPTH bytes. When total exceeds DEPTH, an access at pointer DEPTH is refused and flags an error.
- R7: The error flag stays high until an `err_clr` strobe clears it. When a refused access and `err_clr` fall in the same cycle, the flag ends up set.
- R8: A length write changes base and total from the next cycle on. It does not move a pointer that is already loaded, but accesses are then checked against the new total.
- R9: When an access coincides with a load (a select write, an offset write or `ptr_rst`), the access uses the old pointer and the load sets the next pointer.
- R10: An offset equal to or greater than the selected transaction's length addresses bytes of the following transactions. This is not an error while the address stays inside the valid region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Write one entry of the length table |
| len_idx | input | IDX_W | Transaction whose length is written |
| len_val | input | LEN_W | Length in bytes |
| cnt_we | input | 1 | Write the transaction count |
| cnt_val | input | CNT_W | Number of configured transactions (clamped to NUM_TRANS) |
| sel_we | input | 1 | Write the transaction select (loads the pointer) |
| sel_val | input | IDX_W | Transaction select value |
| ofs_we | input | 1 | Write the byte offset (loads the pointer) |
| ofs_val | input | LEN_W | Byte offset value |
| ptr_rst | input | 1 | Return the pointer to the selected location |
| data_acc | input | 1 | One data-register read or write |
| err_clr | input | 1 | Clear the error flag |
| buf_en | output | 1 | Buffer RAM access enable for this cycle |
| buf_addr | output | ADDR_W | Buffer RAM byte address |
| buf_err | output | 1 | Sticky buffer error flag |

## Verification
The bench builds the block with 8 transactions, 4-bit lengths and a 40-byte buffer. With these values, all eight lengths at their maximum give a total of 120 bytes, well past the physical depth. That makes the DEPTH cap reachable in a few accesses, alongside the ordinary case where the configured total ends the valid region. The small length field also keeps the bases easy to hand-compute when the bench selects a transaction beyond the count and rewrites a length under a loaded pointer.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;

    // How the pointer moves on the next edge
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_STEP = 2'd2
    } ptr_move_e;

endpackage

// File: rtl/bufptr_len_table.sv
module bufptr_len_table #(
    parameter int NUM_TRANS = 64,
    parameter int LEN_W     = 8,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            len_we,
    input  logic [IDX_W-1:0]                len_idx,
    input  logic [LEN_W-1:0]                len_val,
    input  logic                            cnt_we,
    input  logic [CNT_W-1:0]                cnt_val,
    output logic [NUM_TRANS-1:0][LEN_W-1:0] lens,
    output logic [CNT_W-1:0]                count
);

    typedef struct packed {
        logic [NUM_TRANS-1:0][LEN_W-1:0] lens;
        logic [CNT_W-1:0]                cnt;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        if (len_we && (int'(len_idx) < NUM_TRANS)) begin
            tbl_d.lens[len_idx] = len_val;
        end
        if (cnt_we) begin
            tbl_d.cnt = (int'(cnt_val) > NUM_TRANS) ? CNT_W'(NUM_TRANS) : cnt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lens  = tbl_q.lens;
    assign count = tbl_q.cnt;

    // R5: the count that bounds the valid region never names a missing entry
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= NUM_TRANS);

    // R8: a length write is visible in the table on the next cycle
    a_r8_len_written: assert property (@(posedge clk) disable iff (!rst_n)
        (len_we && (int'(len_idx) < NUM_TRANS)) |=> (lens[$past(len_idx)] == $past(len_val)));

endmodule

// File: rtl/bufptr_prefix.sv
module bufptr_prefix #(
    parameter int NUM_TRANS = 64,
    parameter int LEN_W     = 8,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7,
    parameter int PTR_W     = 15
) (
    input  logic [NUM_TRANS-1:0][LEN_W-1:0] lens,
    input  logic [CNT_W-1:0]                count,
    input  logic [IDX_W-1:0]                sel,
    output logic [PTR_W-1:0]                base,
    output logic [PTR_W-1:0]                total
);

    logic [PTR_W-1:0] len_ext [NUM_TRANS];

    // Widen each length once so the running sum cannot overflow
    for (genvar k = 0; k < NUM_TRANS; k++) begin : g_widen
        assign len_ext[k] = PTR_W'(lens[k]);
    end

    logic [PTR_W-1:0] run;

    always_comb begin
        run   = '0;
        base  = '0;
        total = '0;
        for (int k = 0; k < NUM_TRANS; k++) begin
            if (k == int'(sel))   base  = run;
            if (k == int'(count)) total = run;
            run = run + len_ext[k];
        end
        if (int'(sel) >= NUM_TRANS)   base  = run;
        if (int'(count) >= NUM_TRANS) total = run;
    end

endmodule

// File: rtl/bufptr_core.sv
module bufptr_core
    import bufptr_pkg::*;
#(
    parameter int PTR_W  = 15,
    parameter int LEN_W  = 8,
    parameter int IDX_W  = 6,
    parameter int ADDR_W = 13,
    parameter int DEPTH  = 4352
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_val,
    input  logic              ofs_we,
    input  logic [LEN_W-1:0]  ofs_val,
    input  logic              ptr_rst,
    input  logic              acc,
    input  logic              err_clr,
    input  logic [PTR_W-1:0]  base_nxt,
    input  logic [PTR_W-1:0]  total,
    output logic [IDX_W-1:0]  sel_nxt,
    output logic              buf_en,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_err
);

    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic [LEN_W-1:0] ofs;
        logic [PTR_W-1:0] ptr;
        logic             err;
    } core_t;

    core_t core_q, core_d;

    logic [IDX_W-1:0] sel_d;
    logic [LEN_W-1:0] ofs_d;
    logic             in_range;
    logic             hit;
    logic             miss;
    logic             load;
    ptr_move_e        move;

    // Selection registers resolved first: the base lookup depends on them
    always_comb begin
        sel_d = sel_we ? sel_val : core_q.sel;
        ofs_d = ofs_we ? ofs_val : core_q.ofs;
    end

    assign sel_nxt = sel_d;

    always_comb begin
        in_range = (int'(core_q.ptr) < int'(total)) && (int'(core_q.ptr) < DEPTH);
        hit      = acc && in_range;
        miss     = acc && !in_range;
        load     = sel_we || ofs_we || ptr_rst;

        if (load)     move = PTR_LOAD;
        else if (hit) move = PTR_STEP;
        else          move = PTR_HOLD;

        core_d     = core_q;
        core_d.sel = sel_d;
        core_d.ofs = ofs_d;
        case (move)
            PTR_LOAD: core_d.ptr = base_nxt + PTR_W'(ofs_d);
            PTR_STEP: core_d.ptr = core_q.ptr + PTR_W'(1);
            default:  core_d.ptr = core_q.ptr;
        endcase

        if (miss)         core_d.err = 1'b1;
        else if (err_clr) core_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign buf_en   = hit;
    assign buf_addr = ADDR_W'(core_q.ptr);
    assign buf_err  = core_q.err;

    // R3: an accepted access without a load advances the pointer by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !sel_we && !ofs_we && !ptr_rst) |=> (core_q.ptr == $past(core_q.ptr) + PTR_W'(1)));

    // R5: a refused access leaves the pointer in place
    a_r5_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !buf_en && !sel_we && !ofs_we && !ptr_rst) |=> $stable(core_q.ptr));

    // R5: a refused access raises the flag
    a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !buf_en) |=> buf_err);

    // R7: the flag only drops through an explicit clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_err && !err_clr) |=> buf_err);

    // R6: no enabled access leaves the physical buffer
    a_r6_addr_in_depth: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> (int'(core_q.ptr) < DEPTH));

    // R2: a load places the pointer at base plus offset
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we || ofs_we || ptr_rst) |=> (core_q.ptr == $past(base_nxt) + PTR_W'($past(ofs_d))));

endmodule

// File: rtl/bufptr_top.sv
module bufptr_top #(
    parameter int NUM_TRANS = 64,
    parameter int LEN_W     = 8,
    parameter int DEPTH     = 4352,
    localparam int IDX_W    = (NUM_TRANS > 1) ? $clog2(NUM_TRANS) : 1,
    localparam int CNT_W    = $clog2(NUM_TRANS + 1),
    localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PTR_W    = LEN_W + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [IDX_W-1:0]  len_idx,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_val,
    input  logic              ofs_we,
    input  logic [LEN_W-1:0]  ofs_val,
    input  logic              ptr_rst,
    input  logic              data_acc,
    input  logic              err_clr,
    output logic              buf_en,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_err
);

    logic [NUM_TRANS-1:0][LEN_W-1:0] lens;
    logic [CNT_W-1:0]                count;
    logic [IDX_W-1:0]                sel_nxt;
    logic [PTR_W-1:0]                base_nxt;
    logic [PTR_W-1:0]                total;

    bufptr_len_table #(
        .NUM_TRANS (NUM_TRANS),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_we  (len_we),
        .len_idx (len_idx),
        .len_val (len_val),
        .cnt_we  (cnt_we),
        .cnt_val (cnt_val),
        .lens    (lens),
        .count   (count)
    );

    bufptr_prefix #(
        .NUM_TRANS (NUM_TRANS),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .PTR_W     (PTR_W)
    ) u_prefix (
        .lens  (lens),
        .count (count),
        .sel   (sel_nxt),
        .base  (base_nxt),
        .total (total)
    );

    bufptr_core #(
        .PTR_W  (PTR_W),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (sel_we),
        .sel_val  (sel_val),
        .ofs_we   (ofs_we),
        .ofs_val  (ofs_val),
        .ptr_rst  (ptr_rst),
        .acc      (data_acc),
        .err_clr  (err_clr),
        .base_nxt (base_nxt),
        .total    (total),
        .sel_nxt  (sel_nxt),
        .buf_en   (buf_en),
        .buf_addr (buf_addr),
        .buf_err  (buf_err)
    );

endmodule

// File: tb/bufptr_top_tb_top.sv
module bufptr_top_tb_top;

    localparam int NT = 8;
    localparam int LW = 4;
    localparam int DP = 40;

    localparam logic [2:0] OP_LEN = 3'd1;
    localparam logic [2:0] OP_CNT = 3'd2;
    localparam logic [2:0] OP_SEL = 3'd3;
    localparam logic [2:0] OP_OFS = 3'd4;
    localparam logic [2:0] OP_RST = 3'd5;
    localparam logic [2:0] OP_ACC = 3'd6;
    localparam logic [2:0] OP_CLR = 3'd7;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       en;
        logic [7:0] addr;
        logic       err;
    } vec_t;

    localparam int NV = 31;
    // Layout: lengths 3,5,2,4 with count 4 -> bases 0,3,8,10, total 14
    localparam vec_t VECS [NV] = '{
        '{OP_LEN, 8'd0, 8'd3, 1'b0, 8'd0,  1'b0},
        '{OP_LEN, 8'd1, 8'd5, 1'b0, 8'd0,  1'b0},
        '{OP_LEN, 8'd2, 8'd2, 1'b0, 8'd0,  1'b0},
        '{OP_LEN, 8'd3, 8'd4, 1'b0, 8'd0,  1'b0},
        '{OP_CNT, 8'd4, 8'd0, 1'b0, 8'd0,  1'b0},
        '{OP_SEL, 8'd1, 8'd0, 1'b0, 8'd0,  1'b0},   // R2 ptr 3
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd3,  1'b0},   // R3
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd4,  1'b0},   // R3
        '{OP_OFS, 8'd2, 8'd0, 1'b0, 8'd0,  1'b0},   // R2 ptr 5
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd5,  1'b0},
        '{OP_RST, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},   // R4 ptr 5
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd5,  1'b0},
        '{OP_SEL, 8'd3, 8'd0, 1'b0, 8'd0,  1'b0},   // R2 ptr 12
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd12, 1'b0},
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd13, 1'b0},
        '{OP_ACC, 8'd0, 8'd0, 1'b0, 8'd0,  1'b1},   // R5 ptr 14 = total
        '{OP_ACC, 8'd0, 8'd0, 1'b0, 8'd0,  1'b1},   // R5 pointer held
        '{OP_CLR, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},   // R7
        '{OP_OFS, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},   // ptr 10
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd10, 1'b0},
        '{OP_SEL, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},   // ptr 0
        '{OP_OFS, 8'd7, 8'd0, 1'b0, 8'd0,  1'b0},   // R10 ptr 7
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd7,  1'b0},   // R10
        '{OP_SEL, 8'd5, 8'd0, 1'b0, 8'd0,  1'b0},   // beyond count: ptr 21
        '{OP_ACC, 8'd0, 8'd0, 1'b0, 8'd0,  1'b1},   // R5
        '{OP_CLR, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},
        '{OP_OFS, 8'd0, 8'd0, 1'b0, 8'd0,  1'b0},   // ptr 14
        '{OP_LEN, 8'd0, 8'd6, 1'b0, 8'd0,  1'b0},   // R8 total 17, ptr stays
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd14, 1'b0},   // R8
        '{OP_SEL, 8'd2, 8'd0, 1'b0, 8'd0,  1'b0},   // R8 base 11
        '{OP_ACC, 8'd0, 8'd0, 1'b1, 8'd11, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len_we = 1'b0;
    logic [2:0] len_idx = '0;
    logic [3:0] len_val = '0;
    logic       cnt_we = 1'b0;
    logic [3:0] cnt_val = '0;
    logic       sel_we = 1'b0;
    logic [2:0] sel_val = '0;
    logic       ofs_we = 1'b0;
    logic [3:0] ofs_val = '0;
    logic       ptr_rst = 1'b0;
    logic       data_acc = 1'b0;
    logic       err_clr = 1'b0;
    logic       buf_en;
    logic [5:0] buf_addr;
    logic       buf_err;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bufptr_top #(.NUM_TRANS(NT), .LEN_W(LW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .len_we(len_we), .len_idx(len_idx), .len_val(len_val),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .sel_we(sel_we), .sel_val(sel_val),
        .ofs_we(ofs_we), .ofs_val(ofs_val),
        .ptr_rst(ptr_rst), .data_acc(data_acc), .err_clr(err_clr),
        .buf_en(buf_en), .buf_addr(buf_addr), .buf_err(buf_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        len_we = 0; cnt_we = 0; sel_we = 0; ofs_we = 0;
        ptr_rst = 0; data_acc = 0; err_clr = 0;
    endtask

    task automatic set_op(input logic [2:0] op, input int a, input int b);
        case (op)
            OP_LEN: begin len_we = 1; len_idx = 3'(a); len_val = 4'(b); end
            OP_CNT: begin cnt_we = 1; cnt_val = 4'(a); end
            OP_SEL: begin sel_we = 1; sel_val = 3'(a); end
            OP_OFS: begin ofs_we = 1; ofs_val = 4'(a); end
            OP_RST: ptr_rst = 1;
            OP_ACC: data_acc = 1;
            OP_CLR: err_clr = 1;
            default: ;
        endcase
    endtask

    // Drive one op for a cycle; check access outputs mid-cycle, flag after the edge
    task automatic step(input logic [2:0] op, input int a, input int b,
                        input int en, input int addr, input int err, input string req);
        @(negedge clk);
        set_op(op, a, b);
        #1;
        if (op == OP_ACC) begin
            chk({req, " en"}, int'(buf_en), en);
            if (en != 0) chk({req, " addr"}, int'(buf_addr), addr);
        end
        @(posedge clk);
        #1;
        clear_in();
        chk({req, " err"}, int'(buf_err), err);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 err after reset", int'(buf_err), 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, int'(VECS[i].a), int'(VECS[i].b), int'(VECS[i].en),
                 int'(VECS[i].addr), int'(VECS[i].err), $sformatf("vec%0d R2-path", i));
        end

        // R6: all lengths 15 -> total 120 > DEPTH 40
        for (int k = 0; k < NT; k++) step(OP_LEN, k, 15, 0, 0, 0, "R6 cfg");
        step(OP_CNT, 8, 0, 0, 0, 0, "R6 cfg");
        step(OP_SEL, 2, 0, 0, 0, 0, "R6 sel");           // base 30
        step(OP_OFS, 9, 0, 0, 0, 0, "R6 ofs");           // ptr 39
        step(OP_ACC, 0, 0, 1, 39, 0, "R6 last byte");
        step(OP_ACC, 0, 0, 0, 0, 1, "R6 past depth");

        // R7: refused access with clear in the same cycle keeps the flag set
        @(negedge clk);
        data_acc = 1; err_clr = 1;
        @(posedge clk); #1; clear_in();
        chk("R7 set over clear", int'(buf_err), 1);
        step(OP_CLR, 0, 0, 0, 0, 0, "R7 clear");

        // R9: access and pointer reset in one cycle
        step(OP_SEL, 0, 0, 0, 0, 0, "R9 sel");
        step(OP_OFS, 0, 0, 0, 0, 0, "R9 ofs");
        step(OP_ACC, 0, 0, 1, 0, 0, "R9 a0");
        step(OP_ACC, 0, 0, 1, 1, 0, "R9 a1");
        @(negedge clk);
        data_acc = 1; ptr_rst = 1;
        #1;
        chk("R9 old ptr en", int'(buf_en), 1);
        chk("R9 old ptr addr", int'(buf_addr), 2);
        @(posedge clk); #1; clear_in();
        step(OP_ACC, 0, 0, 1, 0, 0, "R9 reloaded");

        // R1: reset again, empty layout refuses, then a fresh layout starts at 0
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        chk("R1 err cleared", int'(buf_err), 0);
        step(OP_ACC, 0, 0, 0, 0, 1, "R1 empty layout");
        step(OP_CLR, 0, 0, 0, 0, 0, "R1 clr");
        step(OP_LEN, 0, 1, 0, 0, 0, "R1 cfg");
        step(OP_CNT, 1, 0, 0, 0, 0, "R1 cfg");
        step(OP_ACC, 0, 0, 1, 0, 0, "R1 ptr zero");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule